// File: doc/BRIEF.md
# Skip-Frame Reset-Voltage Code Sequencer

This block sits in a variable-refresh display timing controller that receives a frame strobe at a fixed 120 Hz rate. A programmed skip count selects the refresh rate. Each refresh frame is followed by that many skip frames, so a count of 0 gives 120 Hz, 11 gives 10 Hz and 119 gives 1 Hz. At every frame strobe the block marks the new frame as refresh or skip. It also reports how deep the frame lies inside the current skip run.

From that depth the block selects an 8-bit reset-voltage code for an external DAC and regulator. The code comes from a six-entry table. Entry 0 serves refresh frames. Skip frames start on entry 1 and climb one entry each time the depth reaches one of four ascending programmable thresholds. Typical settings are 12 and 66 for the first two thresholds, with each step one 25 mV code increment above the previous one. A skip depth of 11 or less never reaches a threshold of 12, so rates from 120 Hz down to 10 Hz keep the base skip code. A vertical sync restarts the sequence.

All configuration (skip count, thresholds, table) is captured only when a refresh frame begins. A skip run therefore always works with one consistent set of values.

Top module: `vrr_reset_code_seq`

## Requirements
- R1: After synchronous reset, and until the first frame strobe, refresh_o, skip_idx_o and dac_code_o are all 0. The first frame strobe after reset always opens a refresh frame.
- R2: The three outputs change only on a clock edge where frame_sync_i is high. In every other cycle they hold their values.
- R3: With a captured skip count N, frames follow the pattern: one refresh frame, then N skip frames, repeating. With N = 0 every frame is a refresh frame.
- R4: skip_idx_o is 0 in a refresh frame and k in the k-th skip frame after it.
- R5: A vsync_i pulse makes the next frame a refresh frame and restarts the index. This holds whether the pulse comes before that frame strobe or in the same cycle as it.
- R6: In a refresh frame, dac_code_o equals table entry 0, taken from lut_i[7:0] as presented at that frame strobe.
- R7: In a skip frame whose index is below threshold 0 (thr_i[7:0]), dac_code_o equals table entry 1 (lut_i[15:8]).
- R8: In a skip frame, dac_code_o equals table entry 1+m, where m is the number of thresholds less than or equal to the index. Entry e sits at lut_i[8e+7:8e] and threshold j at thr_i[8j+7:8j]. Thresholds are given in ascending order, so the selected entry never falls back inside a run.
- R9: Changes to skip_cnt_i, thr_i or lut_i made during a skip run have no effect on that run. They apply from the next refresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync_i | input | 1 | One-cycle strobe at the start of each 120 Hz frame |
| vsync_i | input | 1 | One-cycle vertical sync pulse; forces a refresh at the next frame |
| skip_cnt_i | input | 8 | Number of skip frames after each refresh frame |
| thr_i | input | 32 | Four ascending skip-index thresholds, 8 bits each |
| lut_i | input | 48 | Six 8-bit reset-voltage codes, entry 0 in the low byte |
| refresh_o | output | 1 | 1 while the current frame is a refresh frame |
| skip_idx_o | output | 8 | Position of the current frame within the skip run |
| dac_code_o | output | 8 | Reset-voltage code for the DAC |

## Verification
The assertions guard properties that hold on every cycle:
- the outputs hold still between frame strobes;
- the index stays within the captured skip count and is zero on refresh;
- the index advances by exactly one per skip frame;
- vsync coinciding with a strobe forces a refresh;
- the refresh code tracks table entry 0;
- the table level never falls back inside a run;
- the captured thresholds stay ascending.

Only the bench scenarios can show the full threshold mapping to entries B through F at each boundary index, and that mid-run configuration writes are deferred until the run ends. The same applies to a vsync that arrives cycles before the frame strobe it affects, and to the 10 Hz setting keeping the base skip code throughout.

// File: rtl/vrr_seq_pkg.sv
package vrr_seq_pkg;

    localparam int CNT_W  = 8;
    localparam int CODE_W = 8;
    localparam int LUT_N  = 6;
    localparam int THR_N  = LUT_N - 2;
    localparam int LVL_W  = $clog2(LUT_N);
    localparam int LUT_W  = LUT_N * CODE_W;
    localparam int THR_W  = THR_N * CNT_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [LUT_W-1:0]  lut_t;
    typedef logic [THR_W-1:0]  thr_t;

    typedef struct packed {
        logic  refresh;
        cnt_t  idx;
        lvl_t  lvl;
        code_t code;
    } frame_out_t;

    // Table level for a skip frame: base level 1, plus one per threshold reached.
    function automatic lvl_t step_level(cnt_t idx, thr_t thr);
        lvl_t lvl;
        lvl = lvl_t'(1);
        for (int j = 0; j < THR_N; j++) begin
            if (thr[j*CNT_W +: CNT_W] <= idx) begin
                lvl = lvl + lvl_t'(1);
            end
        end
        return lvl;
    endfunction

    function automatic logic thr_ascending(thr_t thr);
        logic ok;
        ok = 1'b1;
        for (int j = 1; j < THR_N; j++) begin
            if (thr[j*CNT_W +: CNT_W] < thr[(j-1)*CNT_W +: CNT_W]) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/vrr_frame_seq.sv
module vrr_frame_seq
    import vrr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    input  logic vsync,
    input  cnt_t skip_cnt_i,
    output logic load_o,
    output cnt_t next_idx_o,
    output logic refresh_o,
    output cnt_t idx_o
);

    logic restart_q;
    logic refr_q;
    cnt_t skip_q;
    cnt_t idx_q;
    logic run_done;

    assign run_done   = (idx_q == skip_q);
    assign load_o     = frame_sync & (restart_q | vsync | run_done);
    assign next_idx_o = load_o ? '0 : idx_q + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            restart_q <= 1'b1;
            refr_q    <= 1'b0;
            skip_q    <= '0;
            idx_q     <= '0;
        end else begin
            if (frame_sync) begin
                idx_q     <= next_idx_o;
                refr_q    <= load_o;
                restart_q <= 1'b0;
                if (load_o) begin
                    skip_q <= skip_cnt_i;
                end
            end
            if (vsync && !frame_sync) begin
                restart_q <= 1'b1;
            end
        end
    end

    assign refresh_o = refr_q;
    assign idx_o     = idx_q;

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx_q <= skip_q); // R3
    AST_REFRESH_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        refr_q |-> (idx_q == '0)); // R4
    AST_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !restart_q && !vsync && (idx_q != skip_q)) |=> (idx_q == $past(idx_q) + cnt_t'(1))); // R4
    AST_VSYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && vsync) |=> refr_q); // R5

endmodule

// File: rtl/vrr_cfg_shadow.sv
module vrr_cfg_shadow
    import vrr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  lut_t lut_i,
    input  thr_t thr_i,
    output lut_t lut_o,
    output thr_t thr_o
);

    lut_t lut_q;
    thr_t thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lut_q <= '0;
            thr_q <= '0;
        end else if (load) begin
            lut_q <= lut_i;
            thr_q <= thr_i;
        end
    end

    assign lut_o = lut_q;
    assign thr_o = thr_q;

    AST_THR_ORDER: assert property (@(posedge clk) disable iff (rst)
        thr_ascending(thr_q)); // R8

endmodule

// File: rtl/vrr_code_sel.sv
module vrr_code_sel
    import vrr_seq_pkg::*;
(
    input  logic  load,
    input  cnt_t  next_idx,
    input  lut_t  lut_live,
    input  lut_t  lut_held,
    input  thr_t  thr_held,
    output lvl_t  lvl_o,
    output code_t code_o
);

    code_t entry [LUT_N];

    for (genvar e = 0; e < LUT_N; e++) begin : g_entry
        assign entry[e] = lut_held[e*CODE_W +: CODE_W];
    end

    always_comb begin
        if (load) begin
            lvl_o  = '0;
            code_o = lut_live[CODE_W-1:0];
        end else begin
            lvl_o  = step_level(next_idx, thr_held);
            code_o = entry[lvl_o];
        end
    end

endmodule

// File: rtl/vrr_reset_code_seq.sv
module vrr_reset_code_seq
    import vrr_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_sync_i,
    input  logic                  vsync_i,
    input  logic [CNT_W-1:0]      skip_cnt_i,
    input  logic [THR_W-1:0]      thr_i,
    input  logic [LUT_W-1:0]      lut_i,
    output logic                  refresh_o,
    output logic [CNT_W-1:0]      skip_idx_o,
    output logic [CODE_W-1:0]     dac_code_o
);

    logic       load;
    cnt_t       next_idx;
    lut_t       lut_held;
    thr_t       thr_held;
    lvl_t       lvl_next;
    code_t      code_next;
    frame_out_t out_q;

    vrr_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync_i),
        .vsync      (vsync_i),
        .skip_cnt_i (skip_cnt_i),
        .load_o     (load),
        .next_idx_o (next_idx),
        .refresh_o  (out_q.refresh),
        .idx_o      (out_q.idx)
    );

    vrr_cfg_shadow u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .lut_i (lut_i),
        .thr_i (thr_i),
        .lut_o (lut_held),
        .thr_o (thr_held)
    );

    vrr_code_sel u_sel (
        .load     (load),
        .next_idx (next_idx),
        .lut_live (lut_i),
        .lut_held (lut_held),
        .thr_held (thr_held),
        .lvl_o    (lvl_next),
        .code_o   (code_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.lvl  <= '0;
            out_q.code <= '0;
        end else if (frame_sync_i) begin
            out_q.lvl  <= lvl_next;
            out_q.code <= code_next;
        end
    end

    assign refresh_o  = out_q.refresh;
    assign skip_idx_o = out_q.idx;
    assign dac_code_o = out_q.code;

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_sync_i |=> ($stable(dac_code_o) && $stable(skip_idx_o) && $stable(refresh_o))); // R2
    AST_REFRESH_CODE: assert property (@(posedge clk) disable iff (rst)
        (frame_sync_i && load) |=> (dac_code_o == $past(lut_i[CODE_W-1:0]))); // R6
    AST_LEVEL_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (frame_sync_i && !load) |=> (out_q.lvl >= $past(out_q.lvl))); // R8

endmodule

// File: tb/vrr_reset_code_seq_bench.sv
module vrr_reset_code_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync_i = 1'b0;
    logic        vsync_i = 1'b0;
    logic [7:0]  skip_cnt_i = '0;
    logic [31:0] thr_i = '0;
    logic [47:0] lut_i = '0;
    logic        refresh_o;
    logic [7:0]  skip_idx_o;
    logic [7:0]  dac_code_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       r;
        logic [7:0] idx;
        logic [7:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last;
    bit   have_last = 1'b0;

    // reference model state
    bit         m_pend = 1'b1;
    logic [7:0] m_pos  = '0;
    logic [7:0] m_skip = '0;
    logic [47:0] m_lut = '0;
    logic [31:0] m_thr = '0;

    always #2 clk = ~clk;

    vrr_reset_code_seq u_vrr_reset_code_seq (
        .clk          (clk),
        .rst          (rst),
        .frame_sync_i (frame_sync_i),
        .vsync_i      (vsync_i),
        .skip_cnt_i   (skip_cnt_i),
        .thr_i        (thr_i),
        .lut_i        (lut_i),
        .refresh_o    (refresh_o),
        .skip_idx_o   (skip_idx_o),
        .dac_code_o   (dac_code_o)
    );

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: one frame strobe, optionally with vsync; expected item queued
    task automatic frame(input bit vs);
        exp_t e;
        int   m;
        @(negedge clk);
        frame_sync_i = 1'b1;
        vsync_i      = vs;
        if (m_pend || vs || (m_pos == m_skip)) begin
            m_pos  = '0;
            m_skip = skip_cnt_i;
            m_lut  = lut_i;
            m_thr  = thr_i;
            e.r    = 1'b1;
            e.idx  = '0;
            e.code = lut_i[7:0];
            e.tag  = "R6";
        end else begin
            m_pos  = m_pos + 8'd1;
            m = 0;
            for (int j = 0; j < 4; j++) if (m_thr[8*j +: 8] <= m_pos) m++;
            e.r    = 1'b0;
            e.idx  = m_pos;
            e.code = m_lut[8*(1+m) +: 8];
            e.tag  = (m == 0) ? "R7" : "R8";
        end
        m_pend = 1'b0;
        exp_q.push_back(e);
        @(negedge clk);
        frame_sync_i = 1'b0;
        vsync_i      = 1'b0;
        @(negedge clk);
    endtask

    task automatic vsync_only();
        @(negedge clk);
        vsync_i = 1'b1;
        m_pend  = 1'b1;
        @(negedge clk);
        vsync_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) frame(1'b0);
    endtask

    // monitor: compare on frame edges, check hold otherwise
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && frame_sync_i === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("R3", "unexpected frame", 1, 0);
                end else begin
                    last = exp_q.pop_front();
                    have_last = 1'b1;
                    check("R3", "refresh flag", int'(refresh_o), int'(last.r));
                    check("R4", "skip index", int'(skip_idx_o), int'(last.idx));
                    check(last.tag, "dac code", int'(dac_code_o), int'(last.code));
                end
            end else if (!rst && have_last) begin
                @(negedge clk);
                check("R2", "held code", int'(dac_code_o), int'(last.code));
                check("R2", "held index", int'(skip_idx_o), int'(last.idx));
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        lut_i      = {8'd60, 8'd50, 8'd44, 8'd43, 8'd42, 8'd30};
        thr_i      = {8'd250, 8'd200, 8'd66, 8'd12};
        skip_cnt_i = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state before any frame
        check("R1", "refresh after reset", int'(refresh_o), 0);
        check("R1", "index after reset", int'(skip_idx_o), 0);
        check("R1", "code after reset", int'(dac_code_o), 0);

        // R3: skip count 0, every frame refresh (R6 code A)
        frames(4);

        // R7: 10 Hz setting, index never reaches threshold 12
        skip_cnt_i = 8'd11;
        frames(14);
        // R9: new settings mid-run, current run still ends at 11
        skip_cnt_i = 8'd119;
        thr_i      = {8'd110, 8'd100, 8'd66, 8'd12};
        lut_i      = {8'd70, 8'd65, 8'd46, 8'd45, 8'd44, 8'd31};
        frames(12);

        // 1 Hz run, levels C/D/E/F; mid-run table change deferred (R9)
        frames(30);
        lut_i = {8'd99, 8'd98, 8'd97, 8'd96, 8'd95, 8'd94};
        frames(95);

        // R5: vsync ahead of the strobe restarts the sequence
        frames(20);
        vsync_only();
        frames(5);
        // R5: vsync coincident with a strobe
        frame(1'b1);
        frames(3);

        // R8: threshold boundaries at indices 1..4
        skip_cnt_i = 8'd5;
        thr_i      = {8'd4, 8'd3, 8'd2, 8'd1};
        lut_i      = {8'd16, 8'd15, 8'd14, 8'd13, 8'd12, 8'd11};
        frame(1'b1);
        frames(14);

        repeat (4) @(negedge clk);
        check("R3", "queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule